// File: doc/BRIEF.md
# Half-Warp Access Merge Checker

This block looks at one memory request from a group of sixteen parallel lanes. Each lane supplies a byte address and an active bit. The whole group shares one element-size code. The block decides whether the active lanes together touch one naturally aligned segment, with each lane reading its own slot. In that case it reports one merged transaction: a segment base and a segment length in bytes. The segment is sixteen elements long, so it spans 64, 128 or 256 bytes for 4, 8 or 16-byte elements.

When the request cannot be merged, the block issues one transaction per active lane instead. These come out in rising lane order over a valid/ready stream, and the final one is flagged. Lanes that are switched off never break a merge and never produce a transaction. A request with no active lane produces nothing at all.

A request is accepted only while the block is idle. The verdict appears two clock edges after acceptance. Element-size code 3 stands for 12-byte elements, which can never be merged.

Top module: `hwc_coalescer`

## Requirements
- R1: After reset, `seg_valid` and `txn_valid` are low and `req_ready` is high.
- R2: With size code 0 (4-byte elements), a request is merged when every active lane k addresses base + 4k and base is a multiple of 64. The block then raises `seg_valid` for exactly one cycle, on the second rising edge after acceptance, with `seg_base` = base and `seg_len` = 64.
- R3: With size code 1 (8-byte elements), the merge rule uses stride 8 and a 128-byte aligned base, and `seg_len` = 128.
- R4: With size code 2 (16-byte elements), the merge rule uses stride 16 and a 256-byte aligned base, and `seg_len` = 256.
- R5: A base that is not a multiple of the segment length forces per-lane transactions, even when the lane addresses are consecutive.
- R6: If any active lane addresses a slot other than its own lane index, per-lane transactions are forced.
- R7: Inactive lanes are ignored when deciding a merge, whatever their addresses. This holds when lane 0 is inactive, and `seg_base` is still the aligned segment start.
- R8: Size code 3 (12-byte elements) is never merged.
- R9: When no merge is possible, exactly one transaction is issued per active lane, in ascending lane order. Each carries `txn_lane` and that lane's address, and `txn_last` is high only on the final one. The first transaction is valid on the second edge after acceptance. `seg_valid` stays low throughout.
- R10: While `txn_valid` is high and `txn_ready` is low, the transaction on `txn_lane`, `txn_addr` and `txn_last` holds unchanged.
- R11: A request with an all-zero mask raises neither `seg_valid` nor `txn_valid`, and `req_ready` returns high on the second edge after acceptance.
- R12: `req_ready` is low from acceptance until the request is finished. A `req_valid` pulse in that window is ignored and adds no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_mask | input | LANES | Per-lane active bits, bit k = lane k |
| req_addr | input | LANES*AW | Lane k byte address in bits [k*AW +: AW] |
| req_size | input | 2 | Element size: 0=4 B, 1=8 B, 2=16 B, 3=12 B |
| seg_valid | output | 1 | One-cycle pulse, merged transaction |
| seg_base | output | AW | Merged segment start address |
| seg_len | output | LEN_W | Merged segment length in bytes |
| txn_valid | output | 1 | Per-lane transaction present |
| txn_ready | input | 1 | Consumer takes the transaction |
| txn_lane | output | IW | Lane index of the transaction |
| txn_addr | output | AW | Address of that lane |
| txn_last | output | 1 | Final per-lane transaction of the request |

## Verification
The bench builds the block with its default sixteen lanes and 32-bit addresses. At these values all three mergeable segment lengths are reachable, and so is a request whose only active lanes are lane 0 and lane 15, the two ends of the anchor search. With addresses this wide, a segment can also be placed on a boundary that is aligned for 128 bytes but not for 256, which makes the 16-byte alignment rule separable from the 8-byte one. Back-pressure and a request offered while busy are applied during a per-lane transaction sequence.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

  typedef enum logic [1:0] {
    SZ_W4  = 2'd0,
    SZ_W8  = 2'd1,
    SZ_W16 = 2'd2,
    SZ_W12 = 2'd3
  } elem_sz_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_EMIT = 2'd2
  } hwc_state_e;

  // log2 of the element width for the mergeable sizes
  function automatic logic [2:0] sz_shift(elem_sz_e s);
    case (s)
      SZ_W4:   return 3'd2;
      SZ_W8:   return 3'd3;
      SZ_W16:  return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/hwc_lane_pick.sv
module hwc_lane_pick #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic          single_o
);

  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o    = |mask_i;
  assign single_o = any_o && ((mask_i & (mask_i - N'(1))) == '0);

endmodule

// File: rtl/hwc_seg_rule.sv
module hwc_seg_rule
  import hwc_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32,
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int LEN_W = $clog2(LANES * 16) + 1
) (
  input  logic [LANES-1:0]    mask_i,
  input  logic [LANES*AW-1:0] addr_i,
  input  elem_sz_e            size_i,
  output logic                any_o,
  output logic                ok_o,
  output logic [AW-1:0]       base_o,
  output logic [LEN_W-1:0]    len_o
);

  logic [IW-1:0]    anchor;
  logic             anchor_single;
  logic [2:0]       shift;
  logic [AW-1:0]    anchor_addr;
  logic [LANES-1:0] lane_hit;
  logic             aligned;

  hwc_lane_pick #(.N(LANES)) u_anchor (
    .mask_i   (mask_i),
    .any_o    (any_o),
    .idx_o    (anchor),
    .single_o (anchor_single)
  );

  assign shift       = sz_shift(size_i);
  assign anchor_addr = addr_i[anchor*AW +: AW];
  assign base_o      = anchor_addr - (AW'(anchor) << shift);
  assign len_o       = LEN_W'(LANES) << shift;
  assign aligned     = (base_o & (AW'(len_o) - AW'(1))) == '0;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_hit[k] = !mask_i[k] ||
                         (addr_i[k*AW +: AW] == base_o + (AW'(k) << shift));
  end

  assign ok_o = any_o && (size_i != SZ_W12) && aligned && (&lane_hit);

  logic unused_single;
  assign unused_single = anchor_single;

endmodule

// File: rtl/hwc_coalescer.sv
module hwc_coalescer
  import hwc_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32,
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int LEN_W = $clog2(LANES * 16) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES-1:0]    req_mask,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [1:0]          req_size,
  output logic                seg_valid,
  output logic [AW-1:0]       seg_base,
  output logic [LEN_W-1:0]    seg_len,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic [IW-1:0]       txn_lane,
  output logic [AW-1:0]       txn_addr,
  output logic                txn_last
);

  hwc_state_e          state;
  logic [LANES-1:0]    cap_mask;
  logic [LANES*AW-1:0] cap_addr;
  elem_sz_e            cap_size;
  logic [LANES-1:0]    pend;

  logic                rule_any;
  logic                rule_ok;
  logic [AW-1:0]       rule_base;
  logic [LEN_W-1:0]    rule_len;

  logic                pick_any;
  logic [IW-1:0]       pick_idx;
  logic                pick_single;

  hwc_seg_rule #(.LANES(LANES), .AW(AW)) u_rule (
    .mask_i (cap_mask),
    .addr_i (cap_addr),
    .size_i (cap_size),
    .any_o  (rule_any),
    .ok_o   (rule_ok),
    .base_o (rule_base),
    .len_o  (rule_len)
  );

  hwc_lane_pick #(.N(LANES)) u_emit (
    .mask_i   (pend),
    .any_o    (pick_any),
    .idx_o    (pick_idx),
    .single_o (pick_single)
  );

  assign req_ready = (state == ST_IDLE);
  assign txn_valid = (state == ST_EMIT) && pick_any;
  assign txn_lane  = pick_idx;
  assign txn_addr  = cap_addr[pick_idx*AW +: AW];
  assign txn_last  = pick_single;

  // request capture: plain data registers without reset
  always_ff @(posedge clk) begin
    if (state == ST_IDLE && req_valid) begin
      cap_mask <= req_mask;
      cap_addr <= req_addr;
      cap_size <= elem_sz_e'(req_size);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pend      <= '0;
      seg_valid <= 1'b0;
      seg_base  <= '0;
      seg_len   <= '0;
    end else begin
      seg_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) state <= ST_EVAL;
        end
        ST_EVAL: begin
          if (!rule_any) begin
            state <= ST_IDLE;
          end else if (rule_ok) begin
            seg_valid <= 1'b1;
            seg_base  <= rule_base;
            seg_len   <= rule_len;
            state     <= ST_IDLE;
          end else begin
            pend  <= cap_mask;
            state <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (txn_ready) begin
            pend[pick_idx] <= 1'b0;
            if (pick_single) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: a stalled transaction holds
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_lane) &&
                                $stable(txn_addr) && $stable(txn_last));

  // R2: merged result is a single-cycle pulse
  a_r2_pulse: assert property (@(posedge clk) disable iff (rst)
    seg_valid |=> !seg_valid);

  // R4: merged length is one of the three power-of-two segment sizes
  a_r4_len: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> $onehot(seg_len) && (seg_len >= LEN_W'(LANES * 4)) &&
                  (seg_len <= LEN_W'(LANES * 16)));

  // R9: merged and per-lane outputs never overlap
  a_r9_excl: assert property (@(posedge clk) disable iff (rst)
    !(seg_valid && txn_valid));

  // R9: lanes leave in strictly rising order
  a_r9_order: assert property (@(posedge clk) disable iff (rst)
    txn_valid && txn_ready && !txn_last |=> txn_valid &&
                                            (txn_lane > $past(txn_lane)));

  // R11: an empty request yields nothing
  a_r11_empty: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EVAL) && (cap_mask == '0) |=> !seg_valid && !txn_valid);

endmodule

// File: tb/tb_hwc_coalescer.sv
module tb_hwc_coalescer;

  localparam int LANES = 16;
  localparam int AW    = 32;
  localparam int IW    = 4;
  localparam int LEN_W = 9;

  typedef struct packed {
    logic [1:0]  sz;
    logic [15:0] mask;
    logic [31:0] base;
    logic [1:0]  mode;   // 0 in order, 1 lanes 0/1 swapped, 3 junk on inactive
    logic        co;     // merge expected
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'hFFFF, 32'h0000_1000, 2'd0, 1'b1},  // R2
    '{2'd1, 16'hFFFF, 32'h0000_2080, 2'd0, 1'b1},  // R3
    '{2'd2, 16'hFFFF, 32'h0000_4100, 2'd0, 1'b1},  // R4
    '{2'd0, 16'hFFFF, 32'h0000_1004, 2'd0, 1'b0},  // R5 off by 4
    '{2'd2, 16'hFFFF, 32'h0000_4080, 2'd0, 1'b0},  // R5 128- not 256-aligned
    '{2'd0, 16'hFFFF, 32'h0000_1000, 2'd1, 1'b0},  // R6 permuted
    '{2'd1, 16'h00F0, 32'h0000_3000, 2'd3, 1'b1},  // R7 lane 0 off
    '{2'd0, 16'h8001, 32'h0000_0040, 2'd3, 1'b1},  // R7 end lanes only
    '{2'd3, 16'hFFFF, 32'h0000_1000, 2'd0, 1'b0},  // R8 12-byte
    '{2'd1, 16'h0A05, 32'h0000_2000, 2'd1, 1'b0}   // R6 partial mask
  };

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic [LANES-1:0]    req_mask = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [1:0]          req_size = '0;
  logic                seg_valid;
  logic [AW-1:0]       seg_base;
  logic [LEN_W-1:0]    seg_len;
  logic                txn_valid;
  logic                txn_ready = 1'b1;
  logic [IW-1:0]       txn_lane;
  logic [AW-1:0]       txn_addr;
  logic                txn_last;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  hwc_coalescer #(.LANES(LANES), .AW(AW)) dut (
    .clk, .rst, .req_valid, .req_ready, .req_mask, .req_addr, .req_size,
    .seg_valid, .seg_base, .seg_len, .txn_valid, .txn_ready, .txn_lane,
    .txn_addr, .txn_last
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] gen_addr(vec_t v, int k);
    int es, slot;
    es   = (v.sz == 2'd0) ? 4 : (v.sz == 2'd1) ? 8 : (v.sz == 2'd2) ? 16 : 12;
    slot = k;
    if (v.mode == 2'd1 && k < 2) slot = 1 - k;
    if (v.mode == 2'd3 && !v.mask[k]) return 32'hDEAD_0000 + 32'(k * 7);
    return v.base + 32'(slot * es);
  endfunction

  task automatic send(vec_t v);
    @(negedge clk);
    req_mask  = v.mask;
    req_size  = v.sz;
    for (int k = 0; k < LANES; k++) req_addr[k*AW +: AW] = gen_addr(v, k);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(vec_t v, bit stall, bit poke);
    int hi;
    string tg;
    send(v);
    @(posedge clk);
    @(negedge clk);
    if (v.co) begin
      tg = (v.sz == 2'd0) ? "R2" : (v.sz == 2'd1) ? "R3" : "R4";
      if (v.mode == 2'd3) tg = "R7";
      chk(seg_valid === 1'b1, tg, "seg_valid", 64'(seg_valid), 1);
      chk(seg_base === v.base, tg, "seg_base", 64'(seg_base), 64'(v.base));
      chk(seg_len === LEN_W'(16 << (v.sz + 2)), tg, "seg_len",
          64'(seg_len), 64'(16 << (v.sz + 2)));
      chk(txn_valid === 1'b0, tg, "txn_valid", 64'(txn_valid), 0);
      @(negedge clk);
      chk(seg_valid === 1'b0, "R2", "pulse width", 64'(seg_valid), 0);
    end else begin
      hi = 0;
      for (int k = 0; k < LANES; k++) if (v.mask[k]) hi = k;
      chk(seg_valid === 1'b0, "R9", "no merge", 64'(seg_valid), 0);
      if (stall) begin
        txn_ready = 1'b0;
        for (int s = 0; s < 3; s++) begin
          if (poke && s == 1) begin
            chk(req_ready === 1'b0, "R12", "busy", 64'(req_ready), 0);
            req_valid = 1'b1;
            req_mask  = '1;
            req_size  = 2'd0;
          end
          @(posedge clk);
          @(negedge clk);
          req_valid = 1'b0;
        end
        chk(txn_valid === 1'b1, "R10", "held valid", 64'(txn_valid), 1);
        txn_ready = 1'b1;
      end
      for (int k = 0; k < LANES; k++) begin
        if (v.mask[k]) begin
          chk(txn_valid === 1'b1, "R9", "txn_valid", 64'(txn_valid), 1);
          chk(txn_lane === IW'(k), stall ? "R10" : "R9", "txn_lane",
              64'(txn_lane), 64'(k));
          chk(txn_addr === gen_addr(v, k), "R9", "txn_addr",
              64'(txn_addr), 64'(gen_addr(v, k)));
          chk(txn_last === (k == hi), "R9", "txn_last",
              64'(txn_last), 64'(k == hi));
          @(posedge clk);
          @(negedge clk);
        end
      end
      chk(txn_valid === 1'b0, "R9", "end of list", 64'(txn_valid), 0);
      chk(req_ready === 1'b1, "R12", "ready again", 64'(req_ready), 1);
      @(negedge clk);
      chk(!seg_valid && !txn_valid, "R12", "poke ignored",
          64'({seg_valid, txn_valid}), 0);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec_t e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(seg_valid === 1'b0, "R1", "seg_valid", 64'(seg_valid), 0);
    chk(txn_valid === 1'b0, "R1", "txn_valid", 64'(txn_valid), 0);
    chk(req_ready === 1'b1, "R1", "req_ready", 64'(req_ready), 1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0, 1'b0);

    // R10 and R12: stall and busy poke on a permuted request
    run_vec(VECS[5], 1'b1, 1'b1);
    run_vec(VECS[9], 1'b1, 1'b0);

    // R11 empty mask
    e = '{2'd0, 16'h0000, 32'h0000_1000, 2'd0, 1'b0};
    send(e);
    chk(req_ready === 1'b0, "R12", "busy in eval", 64'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    chk(!seg_valid && !txn_valid, "R11", "no output",
        64'({seg_valid, txn_valid}), 0);
    chk(req_ready === 1'b1, "R11", "ready", 64'(req_ready), 1);
    @(negedge clk);
    chk(!seg_valid && !txn_valid, "R11", "still quiet",
        64'({seg_valid, txn_valid}), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule